// File: doc/BRIEF.md
# Reloadable Countdown Timer

This block is a memory-mapped countdown timer for a 32-bit register bus. Software parks the timer by clearing its run flag, writes a start count and a reload count, then sets the run flag again. From the following clock the counter steps down by one per cycle. Reaching zero raises a sticky pending flag, which drives the single interrupt line when its mask bit is set.

A reload count of zero makes the timer stop at zero after one expiry. A nonzero reload count makes the counter jump back to that value on the cycle after it reaches zero, so it fires once every reload+1 cycles. The live count is not read directly. A write to a capture command offset copies it into a read-only capture register, which then keeps that value until the next capture. Interrupt servicing follows the usual write-one-to-clear pattern on the pending register.

Top module: `reload_timer`

## Requirements
- R1: After reset every mapped offset reads 0 and `irq` is 0.
- R2: While the run flag (offset 0x08, bit 0) is 0, the counter takes the start count (offset 0x00) on every clock, and the status bit stays 0.
- R3: While the run flag is 1 and the count is nonzero, the count drops by exactly one per clock. This holds from any start count between 1 and 0xFFFFFFFF.
- R4: With reload count (offset 0x04) equal to 0, the counter stops at 0 after one expiry and the pending bit is set exactly once.
- R5: With a nonzero reload count N, a count of 0 is followed by N, and the pending bit is set every N+1 cycles.
- R6: The pending bit (offset 0x18, bit 0) is set on the clock edge where the count goes from 1 to 0. It stays set until a write with bit 0 = 1 clears it. A write with bit 0 = 0 does not change it.
- R7: If a zero event and a clear write fall on the same clock edge, the pending bit ends up set.
- R8: `irq` is 1 exactly when the pending bit and the event mask bit (offset 0x1C, bit 0) are both 1.
- R9: Setting the run flag while the start count is 0 sets the pending bit on that same edge.
- R10: Any write to offset 0x0C captures the current count into the capture register (offset 0x10) on the next clock. The capture register holds that value until the next capture. Writes to offsets 0x10 and 0x14 are ignored.
- R11: Reads of offset 0x0C, of offsets at 0x20 and above, and of any address whose low two bits are nonzero return 0. Writes to such addresses change nothing.
- R12: The status bit (offset 0x14, bit 0) reads 1 exactly when the run flag is 1 and the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (8) | Byte address of the register access |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt: pending AND mask |

## Verification
The hardest case to reach is a pending-clear write landing on the exact edge where the periodic counter hits zero (R7). The bench builds it with a short period, start 2 and reload 3. Every edge is counted from the edge that sets the run flag, and the clear write is placed on the third expiry. The live count is only visible through captures, so counting behaviour is checked by taking two captures a known number of edges apart and comparing the difference.

// File: rtl/rt_pkg.sv
package rt_pkg;
    // Word indexes (byte offset / 4) of the register file
    localparam int IDX_START   = 0;
    localparam int IDX_RELOAD  = 1;
    localparam int IDX_RUN     = 2;
    localparam int IDX_CAPCMD  = 3;
    localparam int IDX_CAPVAL  = 4;
    localparam int IDX_STATUS  = 5;
    localparam int IDX_PEND    = 6;
    localparam int IDX_MASK    = 7;
    localparam int NUM_IDX     = 8;
    // Event bit positions
    localparam int EVT_ZERO    = 0;
    localparam int NUM_EVT     = 1;
endpackage

// File: rtl/rt_counter.sv
module rt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             run_next_i,
    input  logic [CNT_W-1:0] start_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_hit_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!run_i) begin
            s_d.cnt = start_i;
        end else if (s_q.cnt == '0) begin
            s_d.cnt = reload_i;
        end else begin
            s_d.cnt = s_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o      = s_q.cnt;
    assign zero_hit_o = (run_i && s_q.cnt == ONE) ||
                        (!run_i && run_next_i && start_i == '0);

    // R2
    parked_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> s_q.cnt == $past(start_i));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && s_q.cnt != '0) |=> s_q.cnt == $past(s_q.cnt) - ONE);

    // R4
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && s_q.cnt == '0 && reload_i == '0) |=> s_q.cnt == '0);

    // R5
    reload_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && s_q.cnt == '0 && reload_i != '0) |=> s_q.cnt == $past(reload_i));
endmodule

// File: rtl/rt_event.sv
module rt_event #(
    parameter int N_EVT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] hit_i,
    input  logic [N_EVT-1:0] clr_i,
    output logic [N_EVT-1:0] pend_o
);
    typedef struct packed {
        logic [N_EVT-1:0] pend;
    } evt_state_t;

    evt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // a fresh hit outranks a clear on the same edge
        s_d.pend = (s_q.pend & ~clr_i) | hit_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o = s_q.pend;

    for (genvar g = 0; g < N_EVT; g++) begin : g_chk
        // R6
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.pend[g] && !clr_i[g]) |=> s_q.pend[g]);
        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_i[g] && clr_i[g]) |=> s_q.pend[g]);
    end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import rt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [CNT_W-1:0]   start;
        logic [CNT_W-1:0]   reload;
        logic [CNT_W-1:0]   cap;
        logic               run;
        logic [NUM_EVT-1:0] mask;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDX_W-1:0]   widx;
    logic               aligned;
    logic [CNT_W-1:0]   cnt;
    logic               zero_hit;
    logic [NUM_EVT-1:0] hit_vec;
    logic [NUM_EVT-1:0] clr_vec;
    logic [NUM_EVT-1:0] pend;
    logic [NUM_EVT-1:0] status;

    assign widx    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    function automatic logic sel(input logic [IDX_W-1:0] w, input logic al, input int k);
        return al && (w == IDX_W'(k));
    endfunction

    always_comb begin
        r_d = r_q;
        if (wr_en && sel(widx, aligned, IDX_START))  r_d.start  = wr_data[CNT_W-1:0];
        if (wr_en && sel(widx, aligned, IDX_RELOAD)) r_d.reload = wr_data[CNT_W-1:0];
        if (wr_en && sel(widx, aligned, IDX_RUN))    r_d.run    = wr_data[0];
        if (wr_en && sel(widx, aligned, IDX_MASK))   r_d.mask   = wr_data[NUM_EVT-1:0];
        if (wr_en && sel(widx, aligned, IDX_CAPCMD)) r_d.cap    = cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    rt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (r_q.run),
        .run_next_i (r_d.run),
        .start_i    (r_q.start),
        .reload_i   (r_q.reload),
        .cnt_o      (cnt),
        .zero_hit_o (zero_hit)
    );

    always_comb begin
        hit_vec           = '0;
        hit_vec[EVT_ZERO] = zero_hit;
        status            = '0;
        status[EVT_ZERO]  = r_q.run && (cnt == '0);
        clr_vec = (wr_en && sel(widx, aligned, IDX_PEND)) ? wr_data[NUM_EVT-1:0] : '0;
    end

    rt_event #(.N_EVT(NUM_EVT)) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit_vec),
        .clr_i  (clr_vec),
        .pend_o (pend)
    );

    assign irq = |(pend & r_q.mask);

    always_comb begin
        rd_data = '0;
        if (aligned) begin
            if      (widx == IDX_W'(IDX_START))  rd_data = 32'(r_q.start);
            else if (widx == IDX_W'(IDX_RELOAD)) rd_data = 32'(r_q.reload);
            else if (widx == IDX_W'(IDX_RUN))    rd_data = 32'(r_q.run);
            else if (widx == IDX_W'(IDX_CAPVAL)) rd_data = 32'(r_q.cap);
            else if (widx == IDX_W'(IDX_STATUS)) rd_data = 32'(status);
            else if (widx == IDX_W'(IDX_PEND))   rd_data = 32'(pend);
            else if (widx == IDX_W'(IDX_MASK))   rd_data = 32'(r_q.mask);
        end
    end

    // R10
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel(widx, aligned, IDX_CAPCMD)) |=> $stable(r_q.cap));

    // R9
    start_zero_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.run && r_d.run && r_q.start == '0) |=> pend[EVT_ZERO]);
endmodule

// File: tb/test_reload_timer.sv
module test_reload_timer;
    localparam logic [7:0] A_START  = 8'h00;
    localparam logic [7:0] A_RELOAD = 8'h04;
    localparam logic [7:0] A_RUN    = 8'h08;
    localparam logic [7:0] A_CAPCMD = 8'h0C;
    localparam logic [7:0] A_CAPVAL = 8'h10;
    localparam logic [7:0] A_STATUS = 8'h14;
    localparam logic [7:0] A_PEND   = 8'h18;
    localparam logic [7:0] A_MASK   = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    reload_timer i_reload_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq     (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic park();
        wr(A_RUN, 32'd0);
        wr(A_PEND, 32'd1);
        wr(A_MASK, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(8'(i * 4), v);
            chk("R1 reset read", v, 32'd0);
        end
        chk("R1 reset irq", 32'(irq), 32'd0);
    endtask

    task automatic t_parked();
        logic [31:0] v;
        park();
        wr(A_START, 32'h0000_1234);
        repeat (2) @(negedge clk);
        wr(A_CAPCMD, 32'd0);
        rd(A_CAPVAL, v);
        chk("R2 parked count follows start", v, 32'h0000_1234);
        rd(A_STATUS, v);
        chk("R12 status 0 while parked", v, 32'd0);
    endtask

    task automatic t_hold_ro();
        logic [31:0] v;
        wr(A_START, 32'h0000_0099);
        repeat (3) @(negedge clk);
        rd(A_CAPVAL, v);
        chk("R10 capture holds", v, 32'h0000_1234);
        wr(A_CAPVAL, 32'hDEAD_BEEF);
        rd(A_CAPVAL, v);
        chk("R10 capture write ignored", v, 32'h0000_1234);
        wr(A_STATUS, 32'd1);
        rd(A_STATUS, v);
        chk("R10 status write ignored", v, 32'd0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(8'h20, v);
        chk("R11 offset 0x20", v, 32'd0);
        rd(A_CAPCMD, v);
        chk("R11 capture command reads 0", v, 32'd0);
        rd(8'h01, v);
        chk("R11 misaligned read", v, 32'd0);
        wr(8'h01, 32'h55);
        rd(A_START, v);
        chk("R11 misaligned write ignored", v, 32'h0000_0099);
    endtask

    task automatic t_countdown();
        logic [31:0] v1, v2;
        park();
        wr(A_START, 32'hFFFF_FFFF);
        wr(A_RUN, 32'd1);
        wr(A_CAPCMD, 32'd0);
        rd(A_CAPVAL, v1);
        chk("R3 first count is start", v1, 32'hFFFF_FFFF);
        wr(A_CAPCMD, 32'd0);
        rd(A_CAPVAL, v2);
        chk("R3 one step", v2, 32'hFFFF_FFFE);
        repeat (10) @(negedge clk);
        wr(A_CAPCMD, 32'd0);
        rd(A_CAPVAL, v1);
        chk("R3 eleven steps", v1, 32'hFFFF_FFF3);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        park();
        wr(A_START, 32'd5);
        wr(A_RELOAD, 32'd0);
        wr(A_RUN, 32'd1);
        repeat (4) @(negedge clk);
        rd(A_PEND, v);
        chk("R6 no event before 1->0", v, 32'd0);
        @(negedge clk);
        rd(A_PEND, v);
        chk("R6 event on 1->0", v, 32'd1);
        rd(A_STATUS, v);
        chk("R12 status at zero", v, 32'd1);
        repeat (10) @(negedge clk);
        wr(A_CAPCMD, 32'd0);
        rd(A_CAPVAL, v);
        chk("R4 stops at zero", v, 32'd0);
        wr(A_PEND, 32'd1);
        repeat (10) @(negedge clk);
        rd(A_PEND, v);
        chk("R4 fires only once", v, 32'd0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        park();
        wr(A_START, 32'd2);
        wr(A_RELOAD, 32'd3);
        wr(A_RUN, 32'd1);
        @(negedge clk);
        rd(A_PEND, v);
        chk("R5 no event at count 1", v, 32'd0);
        @(negedge clk);
        rd(A_PEND, v);
        chk("R5 first expiry", v, 32'd1);
        wr(A_PEND, 32'd1);
        rd(A_PEND, v);
        chk("R6 write-one clears", v, 32'd0);
        repeat (2) @(negedge clk);
        rd(A_PEND, v);
        chk("R5 quiet within period", v, 32'd0);
        @(negedge clk);
        rd(A_PEND, v);
        chk("R5 second expiry after 4 cycles", v, 32'd1);
        repeat (3) @(negedge clk);
        wr(A_PEND, 32'd1);
        rd(A_PEND, v);
        chk("R7 set wins over clear", v, 32'd1);
        wr(A_PEND, 32'd0);
        rd(A_PEND, v);
        chk("R6 write-zero no effect", v, 32'd1);
        wr(A_PEND, 32'd1);
        wr(A_CAPCMD, 32'd0);
        rd(A_CAPVAL, v);
        chk("R5 reload value after zero", v, 32'd2);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(A_MASK, 32'd1);
        repeat (5) @(negedge clk);
        rd(A_PEND, v);
        chk("R8 pending present", v, 32'd1);
        chk("R8 irq when masked in", 32'(irq), 32'd1);
        wr(A_MASK, 32'd0);
        chk("R8 irq off when masked out", 32'(irq), 32'd0);
    endtask

    task automatic t_start_zero();
        logic [31:0] v;
        park();
        wr(A_START, 32'd0);
        wr(A_RELOAD, 32'd0);
        wr(A_PEND, 32'd1);
        rd(A_PEND, v);
        chk("R9 no event while parked", v, 32'd0);
        wr(A_RUN, 32'd1);
        rd(A_PEND, v);
        chk("R9 event on enable with start 0", v, 32'd1);
        rd(A_STATUS, v);
        chk("R12 status on enable with start 0", v, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_parked();
        t_hold_ro();
        t_unmapped();
        t_countdown();
        t_oneshot();
        t_periodic();
        t_irq();
        t_start_zero();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule